// File: doc/BRIEF.md
# Serial GPIO Bank Interrupt and Data Registers

This block holds the register state for four banks of a serial GPIO expander. Each bank has 32 input bits and 32 output bits. A shift engine outside the block presents the deserialised input bits as a parallel vector and takes the output bits as a parallel vector. Software reaches the block through a simple 32-bit register port. Writes are single-cycle and reads are combinational from the address.

For every input bit the block keeps an interrupt enable, three trigger-type bits and a sticky status bit. The three type bits together choose a single rising edge, a single falling edge, both edges, active-high level or active-low level. Status bits are cleared by writing one. A single interrupt line is raised whenever any enabled status bit in any bank is set.

The value register of a bank returns the sampled input bits when read. A write to the same address loads the bank's output latch, which drives the output pins. A separate read-only register returns the bits currently being driven.

Top module: `sgio_irq_regs`

## Requirements
- R1: Register byte addresses per bank b = 0..3. The value register is at 0x000, 0x01C, 0x038 and 0x090. The interrupt group base G is at 0x004, 0x020, 0x03C and 0x094. Enable is at G+0x00, type0 at G+0x04, type1 at G+0x08, type2 at G+0x0C and status at G+0x10. The output read-back is at 0x070 + 4*b. Any other address reads as zero.
- R2: A read of a bank's value register returns that bank's 32 bits of `gpi` (bank b uses bits 32*b+31 down to 32*b) through a two-flop synchroniser. A change on `gpi` becomes visible after the second rising clock edge.
- R3: A write to a value register loads that bank's output latch. The latch drives its slice of `gpo` from the next edge on, and the read-back register returns the latch. Writes to a read-back address change nothing.
- R4: A pin with type1 = 0 and type2 = 0 is edge-triggered: type0 = 1 selects the rising edge and type0 = 0 the falling edge. An edge is detected by comparing the synchronised sample with the previous cycle's sample, and the status bit is readable as set after the third clock edge following the change on `gpi`.
- R5: A pin with type1 = 0 and type2 = 1 sets its status bit on both edges, whatever type0 holds.
- R6: A pin with type1 = 1 is level-triggered: type0 = 1 selects active-high and type0 = 0 active-low. Status is set again on every cycle that the active synchronised level persists, even directly after a clear.
- R7: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. An all-ones write clears the whole bank when no trigger is active.
- R8: After reset, every enable, type, status and output-latch bit is zero, `gpo` is zero and `irq` is low, so every pin defaults to single falling-edge detection with its interrupt disabled.
- R9: `irq` is high exactly when some bank has a status bit set whose enable bit is also set. Status bits are set whatever the enable holds.
- R10: When a trigger event and a clearing status write hit the same bit in the same cycle, the bit stays set.
- R11: The enable and the three type registers return on read the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` in this cycle |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| gpi | input | 128 | Parallel input bits, 32 per bank |
| gpo | output | 128 | Parallel output latch bits, 32 per bank |
| irq | output | 1 | Combined interrupt of all banks |

## Verification
A wrong trigger decode or a lost history sample shows up as a status bit that differs on the status read, three edges after the input change. If that bit is enabled, `irq` differs in the same cycle. A clear that wins over a set, or that spills into neighbouring bits, shows in the status read on the very next cycle. A mis-decoded address corrupts the read of that address at once, and corrupts `gpo` one edge after a value write. Random register traffic runs over sparse input toggles, with directed sequences for reset, level re-assertion and set-versus-clear collisions. The results are compared every cycle against a bench model of the register state.

// File: rtl/sgio_pkg.sv
package sgio_pkg;
    localparam int unsigned NB = 4;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_VAL, SEL_EN, SEL_T0, SEL_T1, SEL_T2, SEL_ST, SEL_RB
    } sel_e;

    // bank placement is irregular, so the bases are listed per bank
    function automatic logic [AW-1:0] val_base(input int b);
        case (b)
            0:       return AW'(8'h00);
            1:       return AW'(8'h1C);
            2:       return AW'(8'h38);
            default: return AW'(8'h90);
        endcase
    endfunction

    function automatic logic [AW-1:0] grp_base(input int b);
        return val_base(b) + AW'(4);
    endfunction

    function automatic logic [AW-1:0] rb_base(input int b);
        return AW'(8'h70) + AW'(4 * b);
    endfunction
endpackage

// File: rtl/sgio_dec.sv
module sgio_dec
    import sgio_pkg::*;
(
    input  logic [AW-1:0] addr,
    output sel_e          sel,
    output logic [BW-1:0] bank
);
    always_comb begin
        sel  = SEL_NONE;
        bank = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == val_base(b)) begin
                sel = SEL_VAL; bank = BW'(b);
            end else if (addr == grp_base(b)) begin
                sel = SEL_EN;  bank = BW'(b);
            end else if (addr == grp_base(b) + AW'(4)) begin
                sel = SEL_T0;  bank = BW'(b);
            end else if (addr == grp_base(b) + AW'(8)) begin
                sel = SEL_T1;  bank = BW'(b);
            end else if (addr == grp_base(b) + AW'(12)) begin
                sel = SEL_T2;  bank = BW'(b);
            end else if (addr == grp_base(b) + AW'(16)) begin
                sel = SEL_ST;  bank = BW'(b);
            end else if (addr == rb_base(b)) begin
                sel = SEL_RB;  bank = BW'(b);
            end
        end
    end
endmodule

// File: rtl/sgio_bank.sv
module sgio_bank
    import sgio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pins_i,
    input  sel_e          sel_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] out_o,
    output logic [DW-1:0] st_o,
    output logic          hit_o
);
    typedef struct packed {
        logic [DW-1:0] s1;
        logic [DW-1:0] s2;
        logic [DW-1:0] pv;
        logic [DW-1:0] en;
        logic [DW-1:0] t0;
        logic [DW-1:0] t1;
        logic [DW-1:0] t2;
        logic [DW-1:0] st;
        logic [DW-1:0] lat;
    } state_t;

    state_t        q, d;
    logic [DW-1:0] ev_d, rise, fall, lvl, edg, clr;

    always_comb begin
        d = q;
        rise = q.s2 & ~q.pv;
        fall = ~q.s2 & q.pv;
        lvl  = (q.t0 & q.s2) | (~q.t0 & ~q.s2);
        edg  = (q.t2 & (rise | fall)) | (~q.t2 & ((q.t0 & rise) | (~q.t0 & fall)));
        ev_d = (q.t1 & lvl) | (~q.t1 & edg);
        clr  = (wr_i && sel_i == SEL_ST) ? wdata_i : '0;
        d.s1 = pins_i;
        d.s2 = q.s1;
        d.pv = q.s2;
        d.st = (q.st & ~clr) | ev_d;
        if (wr_i) begin
            case (sel_i)
                SEL_VAL: d.lat = wdata_i;
                SEL_EN:  d.en  = wdata_i;
                SEL_T0:  d.t0  = wdata_i;
                SEL_T1:  d.t1  = wdata_i;
                SEL_T2:  d.t2  = wdata_i;
                default: ;
            endcase
        end
        case (sel_i)
            SEL_VAL: rdata_o = q.s2;
            SEL_EN:  rdata_o = q.en;
            SEL_T0:  rdata_o = q.t0;
            SEL_T1:  rdata_o = q.t1;
            SEL_T2:  rdata_o = q.t2;
            SEL_ST:  rdata_o = q.st;
            SEL_RB:  rdata_o = q.lat;
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_o = q.lat;
    assign st_o  = q.st;
    assign hit_o = |(q.en & q.st);

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q.en == '0 && q.t0 == '0 && q.t1 == '0 && q.t2 == '0 && q.st == '0 && q.lat == '0));

    assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_VAL) |=> (out_o == $past(wdata_i)));

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_ST) |=> (($past(q.st) & ~q.st) == '0));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_d) |=> (($past(ev_d) & ~q.st) == '0));
endmodule

// File: rtl/sgio_irq_regs.sv
module sgio_irq_regs
    import sgio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NB*DW-1:0] gpi,
    output logic [NB*DW-1:0] gpo,
    output logic             irq
);
    sel_e             sel;
    logic [BW-1:0]    bank;
    logic [DW-1:0]    brd [NB];
    logic [NB*DW-1:0] st_all;
    logic [NB-1:0]    hit;

    sgio_dec u_dec (.addr(addr), .sel(sel), .bank(bank));

    for (genvar g = 0; g < NB; g++) begin : g_bank
        sgio_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_i  (gpi[g*DW +: DW]),
            .sel_i   ((bank == BW'(g)) ? sel : SEL_NONE),
            .wr_i    (wr_en && bank == BW'(g)),
            .wdata_i (wdata),
            .rdata_o (brd[g]),
            .out_o   (gpo[g*DW +: DW]),
            .st_o    (st_all[g*DW +: DW]),
            .hit_o   (hit[g])
        );
    end

    assign rdata = (sel == SEL_NONE) ? '0 : brd[bank];
    assign irq   = |hit;

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || $past(st_all) != st_all));

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_all != '0));
endmodule

// File: tb/test_sgio_irq_regs.sv
module test_sgio_irq_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] gpi = '0;
    logic [127:0] gpo;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_s1 [4], m_s2 [4], m_pv [4], m_en [4], m_t0 [4], m_t1 [4], m_t2 [4], m_st [4], m_lat [4];

    sgio_irq_regs i_sgio_irq_regs (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .gpi(gpi), .gpo(gpo), .irq(irq));

    always #5 clk = ~clk;

    function automatic logic [7:0] vb(input int b);
        case (b) 0: return 8'h00; 1: return 8'h1C; 2: return 8'h38; default: return 8'h90; endcase
    endfunction
    function automatic logic [7:0] gb(input int b);
        return vb(b) + 8'd4;
    endfunction
    function automatic logic [7:0] rbb(input int b);
        return 8'h70 + 8'(4 * b);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        for (int b = 0; b < 4; b++) begin
            if (a == vb(b))          return m_s2[b];
            if (a == gb(b))          return m_en[b];
            if (a == gb(b) + 8'd4)   return m_t0[b];
            if (a == gb(b) + 8'd8)   return m_t1[b];
            if (a == gb(b) + 8'd12)  return m_t2[b];
            if (a == gb(b) + 8'd16)  return m_st[b];
            if (a == rbb(b))         return m_lat[b];
        end
        return '0;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < 4; b++) r |= |(m_en[b] & m_st[b]);
        return r;
    endfunction

    function automatic logic [127:0] exp_gpo();
        return {m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
    endfunction

    function automatic logic [31:0] trig(input int b);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic now_v, old_v;
            now_v = m_s2[b][i];
            old_v = m_pv[b][i];
            if (m_t1[b][i])      r[i] = m_t0[b][i] ? now_v : !now_v;
            else if (m_t2[b][i]) r[i] = now_v != old_v;
            else if (m_t0[b][i]) r[i] = now_v && !old_v;
            else                 r[i] = !now_v && old_v;
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 4; b++) begin
            m_s1[b] = '0; m_s2[b] = '0; m_pv[b] = '0; m_en[b] = '0; m_t0[b] = '0;
            m_t1[b] = '0; m_t2[b] = '0; m_st[b] = '0; m_lat[b] = '0;
        end
    endtask

    task automatic model_clock(input logic we, input logic [7:0] a, input logic [31:0] wd,
                               input logic [127:0] pins);
        for (int b = 0; b < 4; b++) begin
            logic [31:0] ev, clr;
            ev  = trig(b);
            clr = (we && a == gb(b) + 8'd16) ? wd : '0;
            m_st[b] = (m_st[b] & ~clr) | ev;
            if (we) begin
                if (a == vb(b))         m_lat[b] = wd;
                if (a == gb(b))         m_en[b]  = wd;
                if (a == gb(b) + 8'd4)  m_t0[b]  = wd;
                if (a == gb(b) + 8'd8)  m_t1[b]  = wd;
                if (a == gb(b) + 8'd12) m_t2[b]  = wd;
            end
            m_pv[b] = m_s2[b];
            m_s2[b] = m_s1[b];
            m_s1[b] = pins[b*32 +: 32];
        end
    endtask

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check before the rising edge, then clock the model
    task automatic step(input string tag, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic [127:0] pins);
        @(negedge clk);
        wr_en = we; addr = a; wdata = wd; gpi = pins;
        #1;
        chk(tag, {96'b0, rdata}, {96'b0, exp_rd(a)});
        chk("R9 irq", {127'b0, irq}, {127'b0, exp_irq()});
        chk("R3 gpo", gpo, exp_gpo());
        @(posedge clk);
        model_clock(we, a, wd, pins);
    endtask

    function automatic string tag_of(input logic [7:0] a);
        for (int b = 0; b < 4; b++) begin
            if (a == vb(b)) return "R2 value";
            if (a >= gb(b) && a <= gb(b) + 8'd12) return "R11 enable/type";
            if (a == gb(b) + 8'd16) return "R4 status";
            if (a == rbb(b)) return "R3 readback";
        end
        return "R1 unmapped";
    endfunction

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [127:0] p;
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: all registers zero after reset
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 5; k++) step("R8 reset", 1'b0, gb(b) + 8'(4 * k), '0, '0);
        for (int b = 0; b < 4; b++) step("R8 reset latch", 1'b0, rbb(b), '0, '0);

        // R1: map of all banks, unmapped addresses read zero
        for (int b = 0; b < 4; b++) step("R1 map enable", 1'b1, gb(b), 32'hA500_0000 | 32'(b), '0);
        for (int b = 0; b < 4; b++) step("R1 map enable", 1'b0, gb(b), '0, '0);
        step("R1 unmapped", 1'b0, 8'h18, '0, '0);
        step("R1 unmapped", 1'b0, 8'hFF, '0, '0);

        // R2 / R3: value read, latch write, readback write ignored
        p = {32'h0, 32'h0, 32'hC0DE_0001, 32'h0};
        for (int k = 0; k < 3; k++) step("R2 value", 1'b0, 8'h1C, '0, p);
        step("R3 latch", 1'b1, 8'h38, 32'h1234_5678, p);
        step("R3 readback", 1'b1, 8'h78, 32'hFFFF_FFFF, p);
        step("R3 readback", 1'b0, 8'h78, '0, p);

        // R4 rising on bank0 bit 3, enabled
        step("R11 type0", 1'b1, 8'h08, 32'h8, p);
        step("R11 enable", 1'b1, 8'h04, 32'h8, p);
        p[3] = 1'b1;
        for (int k = 0; k < 4; k++) step("R4 rising", 1'b0, 8'h14, '0, p);
        step("R7 clear one", 1'b1, 8'h14, 32'h8, p);
        step("R7 cleared", 1'b0, 8'h14, '0, p);
        // R4 falling on bank0 bit 4 (default type)
        p[4] = 1'b1;
        for (int k = 0; k < 4; k++) step("R4 falling idle", 1'b0, 8'h14, '0, p);
        p[4] = 1'b0;
        for (int k = 0; k < 4; k++) step("R4 falling", 1'b0, 8'h14, '0, p);
        step("R7 zero write", 1'b1, 8'h14, 32'h0, p);
        step("R7 all ones", 1'b1, 8'h14, 32'hFFFF_FFFF, p);
        step("R7 all ones", 1'b0, 8'h14, '0, p);

        // R5 both edges on bank3 bit 0 with type0 = 1
        step("R5 type2", 1'b1, 8'hA0, 32'h1, p);
        step("R5 type0", 1'b1, 8'h98, 32'h1, p);
        p[96] = 1'b1;
        for (int k = 0; k < 4; k++) step("R5 both rise", 1'b0, 8'hA4, '0, p);
        step("R5 clear", 1'b1, 8'hA4, 32'h1, p);
        p[96] = 1'b0;
        for (int k = 0; k < 4; k++) step("R5 both fall", 1'b0, 8'hA4, '0, p);

        // R6 / R10 level high on bank2 bit 0, status reasserts after clear
        step("R6 type1", 1'b1, 8'h44, 32'h1, p);
        step("R6 type0", 1'b1, 8'h40, 32'h1, p);
        step("R9 enable", 1'b1, 8'h3C, 32'h1, p);
        p[64] = 1'b1;
        for (int k = 0; k < 4; k++) step("R6 level high", 1'b0, 8'h4C, '0, p);
        step("R10 set wins", 1'b1, 8'h4C, 32'hFFFF_FFFF, p);
        step("R10 set wins", 1'b0, 8'h4C, '0, p);
        p[64] = 1'b0;
        for (int k = 0; k < 3; k++) step("R6 level low idle", 1'b0, 8'h4C, '0, p);
        step("R6 clear", 1'b1, 8'h4C, 32'h1, p);
        step("R6 inactive", 1'b0, 8'h4C, '0, p);
        // active-low level
        step("R6 type0 low", 1'b1, 8'h40, 32'h0, p);
        for (int k = 0; k < 2; k++) step("R6 level low", 1'b0, 8'h4C, '0, p);

        // random traffic with sparse input toggles
        for (int i = 0; i < 5000; i++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            logic        we;
            int          b, k;
            b  = int'($urandom % 4);
            k  = int'($urandom % 8);
            case (k)
                0:       a = vb(b);
                6:       a = rbb(b);
                7:       a = 8'($urandom);
                default: a = gb(b) + 8'(4 * (k - 1));
            endcase
            we = ($urandom % 5) < 2;
            wd = $urandom;
            if (($urandom % 4) == 0)
                p[b*32 +: 32] = p[b*32 +: 32] ^ ($urandom & $urandom & $urandom);
            step(tag_of(a), we, a, wd, p);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule